// File: doc/BRIEF.md
# Load Store-Wait Predictor

This block keeps one wait bit per table entry, indexed by a slice of a load's program counter. The issue stage presents a load PC on `query_pc` and reads `query_wait` in the same cycle. A low flag lets the load issue speculatively ahead of older stores whose addresses are not yet known. A high flag makes it hold until every older store has issued.

When the memory ordering checker finds that a speculatively issued load read stale data, it pulses `viol_valid` with that load's PC on `viol_pc`. That sets the matching entry, so the load behaves conservatively from then on. A free-running interval timer wipes the whole table at a fixed period. Loads therefore get a fresh chance to run aggressively after each wipe. Detection of violations, the load/store queue and flush handling sit outside this block.

Top module: `load_wait_predictor`

## Requirements
- R1: A synchronous reset (rst_n low at a clock edge) clears every entry, and `query_wait` is 0 for any PC afterwards until an entry is set.
- R2: `query_wait` is combinational from `query_pc`. It selects the entry given by PC bits [IDX_LSB+IDX_W-1:IDX_LSB] (default [11:2]), and PC bits outside that slice have no effect.
- R3: `viol_valid` high at an edge sets the entry for `viol_pc`, and a query of that entry returns 1 from the following cycle on.
- R4: Two PCs that agree in the index slice share one entry: setting one makes the other read 1.
- R5: A set changes only the addressed entry; all other entries keep their values.
- R6: Setting an entry that is already set leaves the table unchanged.
- R7: Counting clock edges with rst_n high from reset release, every edge whose number is a multiple of CLEAR_PERIOD (default 16384) clears all entries; a bit set before such an edge still reads 1 in the cycle before it and 0 after it.
- R8: When a set and a periodic clear fall on the same edge, the clear wins and the addressed entry reads 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| query_pc | input | PC_W | PC of the load being considered for issue |
| viol_valid | input | 1 | Ordering violation reported this cycle |
| viol_pc | input | PC_W | PC of the load that misspeculated |
| query_wait | output | 1 | 1: load must wait for older stores; 0: may issue speculatively |

## Verification
A violation report and the periodic wipe can land on the same clock edge. The bench runs a small table with a short period. It tracks the interval count itself, drives `viol_valid` in exactly the cycle before a wipe edge, and queries that entry afterwards, expecting 0. It also sets an entry one cycle earlier and checks that the entry reads 1 just before the wipe and 0 just after it. That pins the wipe edge to the exact cycle.

// File: rtl/lwp_pkg.sv
// Package: shared defaults and a width helper for the load wait predictor.
// Assumes: callers pass a period of at least 1.
package lwp_pkg;

    localparam int unsigned LWP_PC_W         = 32;
    localparam int unsigned LWP_IDX_LSB      = 2;
    localparam int unsigned LWP_IDX_W        = 10;
    localparam int unsigned LWP_CLEAR_PERIOD = 16384;

    // Width of a counter that must hold values 0 .. period-1.
    function automatic int unsigned cnt_width(input int unsigned period);
        return (period <= 2) ? 1 : $clog2(period);
    endfunction

endpackage

// File: rtl/lwp_pc_index.sv
// Module: extracts the table index from a PC.
// Assumes: IDX_LSB + IDX_W <= PC_W; bits outside the slice are deliberately ignored.
module lwp_pc_index #(
    parameter int unsigned PC_W    = 32,
    parameter int unsigned IDX_LSB = 2,
    parameter int unsigned IDX_W   = 10
) (
    input  logic [PC_W-1:0]  pc,
    output logic [IDX_W-1:0] idx
);

    localparam logic [PC_W-1:0] KEEP_MASK =
        ((PC_W'(1) << IDX_W) - PC_W'(1)) << IDX_LSB;

    // Bits outside the slice are folded into a sink so they read as used.
    logic unused_pc_bits;
    assign unused_pc_bits = ^(pc & ~KEEP_MASK);

    // Pick the index slice.
    assign idx = pc[IDX_LSB +: IDX_W];

endmodule

// File: rtl/lwp_interval_timer.sv
// Module: free-running counter that emits a one-cycle clear strobe every PERIOD cycles.
// Assumes: synchronous active-low reset; the strobe is high in the last cycle of each interval.
module lwp_interval_timer #(
    parameter int unsigned PERIOD = 16384
) (
    input  logic clk,
    input  logic rst_n,
    output logic clr_stb
);

    localparam int unsigned CW = lwp_pkg::cnt_width(PERIOD);
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] cnt;

    // Advance the interval count, wrapping at the end of the interval.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= '0;
        else if (cnt == LAST)  cnt <= '0;
        else                   cnt <= cnt + CW'(1);
    end

    // Strobe in the final cycle so the wipe lands on the wrapping edge.
    assign clr_stb = (cnt == LAST);

    p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_stb |=> (cnt == '0));
    p_in_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);
    p_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_stb |=> (cnt == $past(cnt) + CW'(1)));

endmodule

// File: rtl/lwp_wait_table.sv
// Module: array of one-bit wait flags with a single set port, a global clear and one read port.
// Assumes: clear has priority over set; the read is combinational from the stored bits.
module lwp_wait_table #(
    parameter int unsigned IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic [IDX_W-1:0] set_idx,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_bit
);

    localparam int unsigned DEPTH = 1 << IDX_W;

    logic [DEPTH-1:0] bits;

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        // Hold one wait flag: reset and wipe clear it, a matching set raises it.
        always_ff @(posedge clk) begin
            if (!rst_n || clr_en)
                bits[g] <= 1'b0;
            else if (set_en && (set_idx == IDX_W'(g)))
                bits[g] <= 1'b1;
        end
    end

    // Return the addressed flag.
    assign rd_bit = bits[rd_idx];

    p_set_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
        set_en && !clr_en |=> bits[$past(set_idx)]);
    p_only_one_rises_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_en |=> ($countones(bits & ~$past(bits)) <= 1));
    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_en |=> ((bits & $past(bits)) == $past(bits)));
    p_wipe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> (bits == '0));
    p_clear_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en && set_en |=> !bits[$past(set_idx)]);

endmodule

// File: rtl/load_wait_predictor.sv
// Module: top of the load wait predictor; joins index extraction, the flag table and the wipe timer.
// Assumes: one query and at most one violation report per cycle; synchronous active-low reset.
module load_wait_predictor #(
    parameter int unsigned PC_W         = lwp_pkg::LWP_PC_W,
    parameter int unsigned IDX_LSB      = lwp_pkg::LWP_IDX_LSB,
    parameter int unsigned IDX_W        = lwp_pkg::LWP_IDX_W,
    parameter int unsigned CLEAR_PERIOD = lwp_pkg::LWP_CLEAR_PERIOD
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] query_pc,
    input  logic            viol_valid,
    input  logic [PC_W-1:0] viol_pc,
    output logic            query_wait
);

    logic [IDX_W-1:0] q_idx;
    logic [IDX_W-1:0] v_idx;
    logic             clr_stb;

    lwp_pc_index #(.PC_W(PC_W), .IDX_LSB(IDX_LSB), .IDX_W(IDX_W)) u_qidx (
        .pc  (query_pc),
        .idx (q_idx)
    );

    lwp_pc_index #(.PC_W(PC_W), .IDX_LSB(IDX_LSB), .IDX_W(IDX_W)) u_vidx (
        .pc  (viol_pc),
        .idx (v_idx)
    );

    lwp_interval_timer #(.PERIOD(CLEAR_PERIOD)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_stb (clr_stb)
    );

    lwp_wait_table #(.IDX_W(IDX_W)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (viol_valid),
        .set_idx (v_idx),
        .clr_en  (clr_stb),
        .rd_idx  (q_idx),
        .rd_bit  (query_wait)
    );

    p_fresh_query_r3: assert property (@(posedge clk) disable iff (!rst_n)
        viol_valid && !clr_stb |=> (q_idx != $past(v_idx)) || query_wait);
    p_after_wipe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_stb |=> !query_wait);

endmodule

// File: tb/sim_load_wait_predictor.sv
// Bench: sweeps a 16-entry table with a short wipe period against an arithmetic model.
module sim_load_wait_predictor;

    localparam int CLK_PERIOD = 10;
    localparam int PC_W   = 16;
    localparam int IDX_LSB = 2;
    localparam int IDX_W  = 4;
    localparam int DEPTH  = 16;
    localparam int PERIOD = 256;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [PC_W-1:0] query_pc = '0;
    logic            viol_valid = 1'b0;
    logic [PC_W-1:0] viol_pc = '0;
    logic            query_wait;

    int checks = 0;
    int fails  = 0;

    logic [DEPTH-1:0] mdl;
    int               cyc;

    always #(CLK_PERIOD/2) clk = ~clk;

    load_wait_predictor #(.PC_W(PC_W), .IDX_LSB(IDX_LSB), .IDX_W(IDX_W),
                          .CLEAR_PERIOD(PERIOD)) u0 (
        .clk(clk), .rst_n(rst_n), .query_pc(query_pc),
        .viol_valid(viol_valid), .viol_pc(viol_pc), .query_wait(query_wait)
    );

    function automatic int idx_of(input logic [PC_W-1:0] pc);
        return (int'(pc) / 4) % DEPTH;
    endfunction

    function automatic logic [PC_W-1:0] mk_pc(input int i, input int hi, input int lo);
        return PC_W'(hi * 64 + i * 4 + (lo % 4));
    endfunction

    // Reference model: reset and wipe empty it, a set marks one entry, wipe beats set.
    always @(posedge clk) begin
        if (!rst_n) begin
            mdl <= '0; cyc <= 0;
        end else if (cyc == PERIOD - 1) begin
            mdl <= '0; cyc <= 0;
        end else begin
            cyc <= cyc + 1;
            if (viol_valid) mdl[idx_of(viol_pc)] <= 1'b1;
        end
    end

    task automatic step(input logic rn, input logic v, input logic [PC_W-1:0] vpc,
                        input logic [PC_W-1:0] qpc, input string req);
        @(negedge clk);
        rst_n = rn; viol_valid = v; viol_pc = vpc; query_pc = qpc;
        #1;
        if (rst_n) begin
            checks++;
            if (query_wait !== mdl[idx_of(qpc)]) begin
                fails++;
                $display("FAIL %s: pc=%h actual=%b expected=%b", req, qpc,
                         query_wait, mdl[idx_of(qpc)]);
            end
        end
    endtask

    task automatic run_to(input int target);
        while (cyc != target) step(1'b1, 1'b0, '0, mk_pc(cyc % DEPTH, 3, 1), "R2");
    endtask

    initial begin
        repeat (3) step(1'b0, 1'b0, '0, '0, "R1");
        // R1: every entry reads 0 after reset.
        for (int i = 0; i < DEPTH; i++) step(1'b1, 1'b0, '0, mk_pc(i, i, i), "R1");
        // R3/R5/R6: set each entry, re-set it, then sweep all entries.
        for (int i = 0; i < DEPTH; i++) begin
            step(1'b1, 1'b1, mk_pc(i, i * 7, i), mk_pc(i, 0, 0), "R3");
            step(1'b1, 1'b1, mk_pc(i, 5, 3), mk_pc(i, 1, 2), "R6");
            for (int j = 0; j < DEPTH; j++)
                step(1'b1, 1'b0, '0, mk_pc(j, 9, j + 1), (j == i) ? "R3" : "R5");
        end
        // R1: reset mid-run empties the table.
        step(1'b1, 1'b1, mk_pc(6, 2, 0), '0, "R3");
        step(1'b0, 1'b0, '0, '0, "R1");
        for (int i = 0; i < DEPTH; i++) step(1'b1, 1'b0, '0, mk_pc(i, 4, 3), "R1");
        // R2/R4: aliases in high and low bits share the entry.
        step(1'b1, 1'b1, mk_pc(9, 1, 0), mk_pc(9, 200, 3), "R4");
        step(1'b1, 1'b0, '0, mk_pc(9, 200, 3), "R4");
        step(1'b1, 1'b0, '0, mk_pc(9, 0, 2), "R2");
        step(1'b1, 1'b0, '0, mk_pc(8, 1, 0), "R2");
        // R7: set just before a wipe edge, read 1, then 0 after it.
        run_to(PERIOD - 2);
        step(1'b1, 1'b1, mk_pc(3, 0, 0), mk_pc(3, 0, 0), "R7");
        step(1'b1, 1'b0, '0, mk_pc(3, 11, 1), "R7");
        step(1'b1, 1'b0, '0, mk_pc(3, 11, 1), "R7");
        step(1'b1, 1'b0, '0, mk_pc(9, 1, 0), "R7");
        // R8: set coincident with the wipe edge is lost.
        run_to(PERIOD - 1);
        step(1'b1, 1'b1, mk_pc(12, 2, 2), mk_pc(12, 2, 2), "R8");
        step(1'b1, 1'b0, '0, mk_pc(12, 2, 2), "R8");
        step(1'b1, 1'b0, '0, mk_pc(12, 0, 0), "R8");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule